// File: doc/BRIEF.md
# Dual-Accumulator 40-bit Arithmetic Unit

This unit holds two 40-bit accumulators and executes one arithmetic, move, clear, test or compare operation per clock. Each accumulator is viewed as an 8-bit top part, a 16-bit middle word and a 16-bit bottom word. The operands are the accumulators themselves, two 32-bit secondary registers (each split into two 16-bit halves), a 40-bit product input, an 8-bit immediate taken from the opcode, and a 16-bit extension word for the long forms.

Any 16-bit or 8-bit operand is sign-extended and placed at the middle word, which means it is shifted left by 16. It is not aligned to bit 0. Every accepted operation updates four result flags. Compares and tests only update the flags and leave both accumulators unchanged. The surrounding pipeline presents an already-decoded opcode together with `op_valid`. One clock later the new accumulator contents and flags appear, and a one-cycle `wb_valid` strobe marks them.

Top module: `dual_acc_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, both accumulators, all four flags and `wb_valid` become 0.
- R2: A recognised opcode sampled with `op_valid` high updates the accumulators and flags at that edge. `wb_valid` is high for exactly the following cycle. When `op_valid` is low, nothing changes.
- R3: Opcode `0100110d` writes ac0+ac1 into acD. Opcode `0101110d` writes acD−ac(1−d) into acD. Opcode `10000010` sets the flags from ac0−ac1 and writes nothing.
- R4: Opcode `0000010d iiiiiiii` adds the sign-extended 8-bit `i`, shifted left 16, to acD. Opcode `0000001d 00000000` does the same with `imm_word`. Opcode `0000001d 10000000` sets the flags from acD minus that aligned word and writes nothing.
- R5: Opcodes `0111011d` and `0111101d` add and subtract 1. Opcodes `0111010d` and `0111100d` add and subtract 0x10000.
- R6: Opcodes `01000ssd` and `01010ssd` add or subtract a secondary half, sign-extended and shifted left 16. The `ss` field selects 00 = sec0 bits 15:0, 01 = sec1 bits 15:0, 10 = sec0 bits 31:16, 11 = sec1 bits 31:16.
- R7: Opcode `01100ssd` loads the selected half, sign-extended, into acD bits 39:16 and zeroes bits 15:0. Opcode `0110110d` copies ac(1−d) into acD.
- R8: Opcode `1000r001` clears acR. Opcode `0111110d` writes 0−acD.
- R9: Opcodes `0100111d` and `0101111d` add `prod` to acD or subtract `prod` from acD.
- R10: Opcode `1011r001` sets the flags from acR. Opcode `110000hd` sets the flags from acD minus the high half of sec0 (h=0) or sec1 (h=1), aligned to the middle word. Neither writes.
- R11: Flags are computed from a 41-bit sum a + b′ + k. For subtract, negate and compare, b′ = ~b and k = 1; otherwise b′ = b and k = 0.
  - zero = all 40 result bits are 0.
  - sign = result bit 39.
  - carry = sum bit 40.
  - ovf = signed 40-bit overflow.
  - Moves, clear and test use a = 0 or b = 0, so they give carry = ovf = 0.
- R12: All results wrap to 40 bits.
- R13: An opcode matching none of the above leaves the accumulators and flags unchanged and raises no `wb_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode valid this cycle |
| opcode | input | 16 | Decoded operation word |
| imm_word | input | 16 | Extension word for long immediate forms |
| sec0 | input | 32 | Secondary register 0 (high and low halves) |
| sec1 | input | 32 | Secondary register 1 (high and low halves) |
| prod | input | 40 | Product operand |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| flag_zero | output | 1 | Result zero |
| flag_sign | output | 1 | Result bit 39 |
| flag_carry | output | 1 | Carry out of the 40-bit adder |
| flag_ovf | output | 1 | Signed overflow |
| wb_valid | output | 1 | One-cycle strobe after an accepted operation |

## Verification
Some properties are checked on every cycle:
- the strobe only ever follows an accepted opcode;
- the accumulators hold still whenever no strobe is shown;
- at most one accumulator changes per operation;
- zero and sign are never both set;
- a clear always leaves a zeroed accumulator with the zero flag set.

The numeric results need the bench's directed scenarios. These include the middle-word alignment and sign extension of immediates and secondary halves, and the selection by the `ss` field. They also cover carry and overflow at the 40-bit boundaries, compares that leave the accumulators untouched, and rejected opcodes.

// File: rtl/dacc_pkg.sv
// Package: shared control types for the dual-accumulator unit.
// Assumes a single adder path: every operation is expressed as a + b' + k.
package dacc_pkg;

    // First adder operand source
    typedef enum logic [0:0] {
        SA_DST  = 1'b0,
        SA_ZERO = 1'b1
    } src_a_e;

    // Second adder operand source (before optional inversion)
    typedef enum logic [3:0] {
        SB_ZERO    = 4'd0,
        SB_OTHER   = 4'd1,
        SB_DST     = 4'd2,
        SB_SEC     = 4'd3,
        SB_IMM8    = 4'd4,
        SB_IMM16   = 4'd5,
        SB_ONE     = 4'd6,
        SB_MID_ONE = 4'd7,
        SB_PROD    = 4'd8
    } src_b_e;

    // Decoded control word for one operation
    typedef struct packed {
        logic       legal;
        logic       writes;
        logic       dst;
        src_a_e     a_src;
        src_b_e     b_src;
        logic [1:0] sec_sel;
        logic       inv_b;
    } op_ctl_t;

endpackage

// File: rtl/dacc_decode.sv
// Module: dacc_decode
// Turns a 16-bit opcode into an operand-routing control word.
// Assumes opcodes not listed decode to legal = 0 and have no effect.
module dacc_decode
    import dacc_pkg::*;
(
    input  logic [15:0] opcode,
    output op_ctl_t     ctl
);

    // Pure combinational opcode classification
    always_comb begin
        ctl         = '0;
        ctl.a_src   = SA_DST;
        ctl.b_src   = SB_ZERO;
        ctl.dst     = opcode[8];
        ctl.sec_sel = opcode[10:9];
        casez (opcode)
            16'b0100_110?_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_OTHER; end
            16'b0101_110?_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_OTHER; ctl.inv_b = 1'b1; end
            16'b1000_0010_????_????: begin ctl.legal = 1'b1; ctl.dst = 1'b0; ctl.b_src = SB_OTHER; ctl.inv_b = 1'b1; end
            16'b0000_010?_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_IMM8; end
            16'b0000_001?_0000_0000: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_IMM16; end
            16'b0000_001?_1000_0000: begin ctl.legal = 1'b1; ctl.b_src = SB_IMM16; ctl.inv_b = 1'b1; end
            16'b0111_010?_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_MID_ONE; end
            16'b0111_011?_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_ONE; end
            16'b0111_100?_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_MID_ONE; ctl.inv_b = 1'b1; end
            16'b0111_101?_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_ONE; ctl.inv_b = 1'b1; end
            16'b0111_110?_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.a_src = SA_ZERO; ctl.b_src = SB_DST; ctl.inv_b = 1'b1; end
            16'b0100_0???_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_SEC; end
            16'b0101_0???_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_SEC; ctl.inv_b = 1'b1; end
            16'b0110_0???_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.a_src = SA_ZERO; ctl.b_src = SB_SEC; end
            16'b1000_?001_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.dst = opcode[11]; ctl.a_src = SA_ZERO; end
            16'b0100_111?_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_PROD; end
            16'b0101_111?_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.b_src = SB_PROD; ctl.inv_b = 1'b1; end
            16'b0110_110?_????_????: begin ctl.legal = 1'b1; ctl.writes = 1'b1; ctl.a_src = SA_ZERO; ctl.b_src = SB_OTHER; end
            16'b1011_?001_????_????: begin ctl.legal = 1'b1; ctl.dst = opcode[11]; end
            16'b1100_00??_????_????: begin ctl.legal = 1'b1; ctl.b_src = SB_SEC; ctl.sec_sel = {1'b1, opcode[9]}; ctl.inv_b = 1'b1; end
            default: ctl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/dacc_operand_sel.sv
// Module: dacc_operand_sel
// Routes and aligns the two adder operands. Every narrow operand is
// sign-extended and placed at the middle word (shifted left by WORD_W).
// Assumes ACC_W > 2*WORD_W and WORD_W >= 8.
module dacc_operand_sel
    import dacc_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int WORD_W = 16
) (
    input  op_ctl_t             ctl,
    input  logic [ACC_W-1:0]    acc_dst,
    input  logic [ACC_W-1:0]    acc_oth,
    input  logic [2*WORD_W-1:0] sec0,
    input  logic [2*WORD_W-1:0] sec1,
    input  logic [ACC_W-1:0]    prod,
    input  logic [WORD_W-1:0]   imm_word,
    input  logic [7:0]          imm8,
    output logic [ACC_W-1:0]    opa,
    output logic [ACC_W-1:0]    opb
);
    localparam int TOP_W  = ACC_W - 2*WORD_W;
    localparam int EXT8_W = ACC_W - WORD_W - 8;
    localparam int N_HALF = 4;

    logic [WORD_W-1:0] halves [N_HALF];
    logic [ACC_W-1:0]  sec_mid [N_HALF];
    logic [ACC_W-1:0]  imm8_mid;
    logic [ACC_W-1:0]  imm16_mid;

    // Split secondaries: index {hi_sel, reg_sel} and align each to the middle word
    for (genvar g = 0; g < N_HALF; g++) begin : g_half
        if (g < 2) begin : g_low
            assign halves[g] = (g == 0) ? sec0[WORD_W-1:0] : sec1[WORD_W-1:0];
        end else begin : g_high
            assign halves[g] = (g == 2) ? sec0[2*WORD_W-1:WORD_W] : sec1[2*WORD_W-1:WORD_W];
        end
        assign sec_mid[g] = {{TOP_W{halves[g][WORD_W-1]}}, halves[g], {WORD_W{1'b0}}};
    end

    assign imm8_mid  = {{EXT8_W{imm8[7]}}, imm8, {WORD_W{1'b0}}};
    assign imm16_mid = {{TOP_W{imm_word[WORD_W-1]}}, imm_word, {WORD_W{1'b0}}};

    // First operand: destination accumulator or zero
    always_comb begin
        opa = (ctl.a_src == SA_ZERO) ? '0 : acc_dst;
    end

    // Second operand multiplexer
    always_comb begin
        case (ctl.b_src)
            SB_OTHER:   opb = acc_oth;
            SB_DST:     opb = acc_dst;
            SB_SEC:     opb = sec_mid[ctl.sec_sel];
            SB_IMM8:    opb = imm8_mid;
            SB_IMM16:   opb = imm16_mid;
            SB_ONE:     opb = {{(ACC_W-1){1'b0}}, 1'b1};
            SB_MID_ONE: opb = {{(ACC_W-WORD_W-1){1'b0}}, 1'b1, {WORD_W{1'b0}}};
            SB_PROD:    opb = prod;
            default:    opb = '0;
        endcase
    end

endmodule

// File: rtl/dacc_adder.sv
// Module: dacc_adder
// Single ACC_W-bit adder computing a + (inv ? ~b : b) + inv, with flags.
// Assumes inv is set for every subtract, negate and compare.
module dacc_adder #(
    parameter int ACC_W = 40
) (
    input  logic [ACC_W-1:0] a,
    input  logic [ACC_W-1:0] b,
    input  logic             inv,
    output logic [ACC_W-1:0] res,
    output logic             zero,
    output logic             sign,
    output logic             carry,
    output logic             ovf
);
    logic [ACC_W-1:0] b_eff;
    logic [ACC_W:0]   sum;

    // Add with optional two's-complement of b, then derive flags
    always_comb begin
        b_eff = inv ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{ACC_W{1'b0}}, inv};
        res   = sum[ACC_W-1:0];
        carry = sum[ACC_W];
        zero  = (res == '0);
        sign  = res[ACC_W-1];
        ovf   = (a[ACC_W-1] == b_eff[ACC_W-1]) && (res[ACC_W-1] != a[ACC_W-1]);
    end

endmodule

// File: rtl/dual_acc_alu.sv
// Module: dual_acc_alu
// Two ACC_W-bit accumulators with a one-cycle arithmetic/move/compare path.
// Assumes opcode and imm_word are stable in the cycle op_valid is high.
module dual_acc_alu
    import dacc_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [15:0]         opcode,
    input  logic [WORD_W-1:0]   imm_word,
    input  logic [2*WORD_W-1:0] sec0,
    input  logic [2*WORD_W-1:0] sec1,
    input  logic [ACC_W-1:0]    prod,
    output logic [ACC_W-1:0]    acc0,
    output logic [ACC_W-1:0]    acc1,
    output logic                flag_zero,
    output logic                flag_sign,
    output logic                flag_carry,
    output logic                flag_ovf,
    output logic                wb_valid
);
    localparam int N_ACC = 2;

    op_ctl_t          ctl;
    logic [ACC_W-1:0] acc_q [N_ACC];
    logic [ACC_W-1:0] acc_dst, acc_oth, opa, opb, res;
    logic             z_n, s_n, c_n, v_n;
    logic             fire;

    dacc_decode u_dec (
        .opcode (opcode),
        .ctl    (ctl)
    );

    // Pick destination and partner accumulator
    always_comb begin
        acc_dst = acc_q[ctl.dst];
        acc_oth = acc_q[~ctl.dst];
        fire    = op_valid && ctl.legal;
    end

    dacc_operand_sel #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_sel (
        .ctl      (ctl),
        .acc_dst  (acc_dst),
        .acc_oth  (acc_oth),
        .sec0     (sec0),
        .sec1     (sec1),
        .prod     (prod),
        .imm_word (imm_word),
        .imm8     (opcode[7:0]),
        .opa      (opa),
        .opb      (opb)
    );

    dacc_adder #(.ACC_W(ACC_W)) u_add (
        .a     (opa),
        .b     (opb),
        .inv   (ctl.inv_b),
        .res   (res),
        .zero  (z_n),
        .sign  (s_n),
        .carry (c_n),
        .ovf   (v_n)
    );

    // Accumulator registers: one per index, written only when selected
    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[g] <= '0;
            else if (fire && ctl.writes && (ctl.dst == g[0]))
                acc_q[g] <= res;
        end
    end

    // Flag and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_zero  <= 1'b0;
            flag_sign  <= 1'b0;
            flag_carry <= 1'b0;
            flag_ovf   <= 1'b0;
            wb_valid   <= 1'b0;
        end else begin
            wb_valid <= fire;
            if (fire) begin
                flag_zero  <= z_n;
                flag_sign  <= s_n;
                flag_carry <= c_n;
                flag_ovf   <= v_n;
            end
        end
    end

    assign acc0 = acc_q[0];
    assign acc1 = acc_q[1];

endmodule

// File: rtl/dual_acc_alu_chk.sv
// Module: dual_acc_alu_chk
// Cycle-level properties of dual_acc_alu, attached by bind.
// Assumes reset is held for at least two clock edges at start.
module dual_acc_alu_chk #(
    parameter int ACC_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [15:8]      op_hi,
    input logic [ACC_W-1:0] acc0,
    input logic [ACC_W-1:0] acc1,
    input logic             flag_zero,
    input logic             flag_sign,
    input logic             wb_valid
);

    // R2
    strobe_follows_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(op_valid));

    // R2
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> ($stable(acc0) && $stable(acc1)));

    // R3
    single_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc0) |-> $stable(acc1));

    // R11
    zero_not_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero |-> !flag_sign);

    // R8
    clear_gives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_hi[15:12] == 4'b1000 && op_hi[10:8] == 3'b001)
        |=> (flag_zero && (acc0 == '0 || acc1 == '0)));

    // R1
    always @(posedge clk) begin
        if (rst_n && $past(!rst_n))
            reset_state_chk: assert (!wb_valid);
    end

endmodule

bind dual_acc_alu dual_acc_alu_chk #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_hi     (opcode[15:8]),
    .acc0      (acc0),
    .acc1      (acc1),
    .flag_zero (flag_zero),
    .flag_sign (flag_sign),
    .wb_valid  (wb_valid)
);

// File: tb/test_dual_acc_alu.sv
`timescale 1ns/1ps
module test_dual_acc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] opcode = '0;
    logic [15:0] imm_word = '0;
    logic [31:0] sec0 = '0;
    logic [31:0] sec1 = '0;
    logic [39:0] prod = '0;
    logic [39:0] acc0, acc1;
    logic        flag_zero, flag_sign, flag_carry, flag_ovf, wb_valid;

    int   total = 0;
    int   bad = 0;
    logic [39:0] m0 = '0;
    logic [39:0] m1 = '0;

    always #2.5 clk = ~clk;

    dual_acc_alu i_dual_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .imm_word(imm_word), .sec0(sec0), .sec1(sec1), .prod(prod),
        .acc0(acc0), .acc1(acc1), .flag_zero(flag_zero), .flag_sign(flag_sign),
        .flag_carry(flag_carry), .flag_ovf(flag_ovf), .wb_valid(wb_valid)
    );

    function automatic logic [39:0] mid16(input logic [15:0] x);
        return {{8{x[15]}}, x, 16'h0000};
    endfunction

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One operation: expected result from a + b' + k per R11
    task automatic run(input string tag, input logic [15:0] opc, input logic [15:0] imm,
                       input logic [39:0] a, input logic [39:0] b, input bit sub,
                       input bit wr, input bit dst);
        logic [39:0] bb;
        logic [40:0] s;
        logic        v;
        bb = sub ? ~b : b;
        s  = {1'b0, a} + {1'b0, bb} + {40'd0, sub};
        v  = (a[39] == bb[39]) && (s[39] != a[39]);
        if (wr) begin
            if (dst) m1 = s[39:0]; else m0 = s[39:0];
        end
        @(negedge clk);
        opcode = opc; imm_word = imm; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        chk({tag, " acc0"}, acc0, m0);
        chk({tag, " acc1"}, acc1, m1);
        chk({tag, " flags zscv"}, {36'd0, flag_zero, flag_sign, flag_carry, flag_ovf},
            {36'd0, (s[39:0] == 40'd0), s[39], s[40], v});
        chk({tag, " wb_valid R2"}, {39'd0, wb_valid}, 40'd1);
    endtask

    task automatic t_reset;
        chk("R1 reset acc0", acc0, 40'd0);
        chk("R1 reset acc1", acc1, 40'd0);
        chk("R1 reset flags", {35'd0, flag_zero, flag_sign, flag_carry, flag_ovf, wb_valid}, 40'd0);
    endtask

    task automatic t_moves;
        sec0 = 32'h8001_1234;
        sec1 = 32'h0003_FFFE;
        run("R7 movr lo0->ac0", 16'h6000, 16'h0, 40'd0, mid16(16'h1234), 0, 1, 0);
        run("R7 movr hi1->ac1", 16'h6700, 16'h0, 40'd0, mid16(16'h0003), 0, 1, 1);
        run("R7 movr hi0->ac1", 16'h6500, 16'h0, 40'd0, mid16(16'h8001), 0, 1, 1);
        run("R7 mov ac1->ac0",  16'h6C00, 16'h0, 40'd0, m1, 0, 1, 0);
        run("R7 movr lo1->ac0", 16'h6200, 16'h0, 40'd0, mid16(16'hFFFE), 0, 1, 0);
    endtask

    task automatic t_acc_addsub;
        run("R3 add into ac1", 16'h4D00, 16'h0, m1, m0, 0, 1, 1);
        run("R3 sub ac0-ac1",  16'h5C00, 16'h0, m0, m1, 1, 1, 0);
        run("R3 cmp no write", 16'h8200, 16'h0, m0, m1, 1, 0, 0);
    endtask

    task automatic t_immediates;
        run("R4 short imm -3",  16'h04FD, 16'h0, m0, mid16(16'hFFFD), 0, 1, 0);
        run("R4 short imm +7f", 16'h057F, 16'h0, m1, mid16(16'h007F), 0, 1, 1);
        run("R4 long imm",      16'h0200, 16'h8000, m0, mid16(16'h8000), 0, 1, 0);
        run("R4 long cmp",      16'h0380, 16'h1234, m1, mid16(16'h1234), 1, 0, 1);
    endtask

    task automatic t_incdec;
        run("R5 inc",  16'h7600, 16'h0, m0, 40'd1, 0, 1, 0);
        run("R5 dec",  16'h7B00, 16'h0, m1, 40'd1, 1, 1, 1);
        run("R5 incm", 16'h7400, 16'h0, m0, 40'h10000, 0, 1, 0);
        run("R5 decm", 16'h7900, 16'h0, m1, 40'h10000, 1, 1, 1);
    endtask

    task automatic t_secondary;
        sec0 = 32'h7FFF_0102;
        sec1 = 32'hC000_F00F;
        run("R6 addr ss00", 16'h4000, 16'h0, m0, mid16(16'h0102), 0, 1, 0);
        run("R6 addr ss01", 16'h4300, 16'h0, m1, mid16(16'hF00F), 0, 1, 1);
        run("R6 subr ss10", 16'h5400, 16'h0, m0, mid16(16'h7FFF), 1, 1, 0);
        run("R6 subr ss11", 16'h5700, 16'h0, m1, mid16(16'hC000), 1, 1, 1);
    endtask

    task automatic t_clear_neg;
        run("R8 neg ac1",   16'h7D00, 16'h0, 40'd0, m1, 1, 1, 1);
        run("R8 clr ac0",   16'h8100, 16'h0, 40'd0, 40'd0, 0, 1, 0);
        run("R8 neg zero",  16'h7C00, 16'h0, 40'd0, 40'd0, 1, 1, 0);
        run("R8 clr ac1",   16'h8900, 16'h0, 40'd0, 40'd0, 0, 1, 1);
    endtask

    task automatic t_product;
        prod = 40'h7F_FFFF_FFFF;
        run("R9 addp ac0", 16'h4E00, 16'h0, m0, prod, 0, 1, 0);
        prod = 40'h00_0000_0005;
        run("R9 subp ac1", 16'h5F00, 16'h0, m1, prod, 1, 1, 1);
    endtask

    task automatic t_test_cmpar;
        sec1 = 32'hFFFB_0000;
        run("R10 tst ac1",   16'hB900, 16'h0, m1, 40'd0, 0, 0, 1);
        run("R10 tst ac0",   16'hB100, 16'h0, m0, 40'd0, 0, 0, 0);
        run("R10 cmpar h1",  16'hC200, 16'h0, m0, mid16(16'hFFFB), 1, 0, 0);
        run("R10 cmpar h0",  16'hC100, 16'h0, m1, mid16(sec0[31:16]), 1, 0, 1);
    endtask

    task automatic t_flags_wrap;
        // ac0 = 7F_FFFF_FFFF from R9: increment overflows to 80_0000_0000
        run("R11 R12 inc overflow", 16'h7600, 16'h0, m0, 40'd1, 0, 1, 0);
        run("R11 neg most negative", 16'h7C00, 16'h0, 40'd0, m0, 1, 1, 0);
        run("R11 clr ac1",  16'h8900, 16'h0, 40'd0, 40'd0, 0, 1, 1);
        run("R11 R12 dec wrap", 16'h7B00, 16'h0, m1, 40'd1, 1, 1, 1);
        run("R11 R12 inc carry", 16'h7700, 16'h0, m1, 40'd1, 0, 1, 1);
    endtask

    task automatic t_ignored;
        logic [3:0] f_before;
        run("R2 mark flags", 16'h7600, 16'h0, m0, 40'd1, 0, 1, 0);
        @(negedge clk);
        chk("R2 strobe one cycle", {39'd0, wb_valid}, 40'd0);
        f_before = {flag_zero, flag_sign, flag_carry, flag_ovf};
        opcode = 16'h8100; op_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2 no valid acc0", acc0, m0);
        chk("R2 no valid wb", {39'd0, wb_valid}, 40'd0);
        opcode = 16'hFFFF; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R13 illegal wb", {39'd0, wb_valid}, 40'd0);
        chk("R13 illegal acc0", acc0, m0);
        chk("R13 illegal acc1", acc1, m1);
        chk("R13 illegal flags", {36'd0, flag_zero, flag_sign, flag_carry, flag_ovf}, {36'd0, f_before});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_moves;
        t_acc_addsub;
        t_immediates;
        t_incdec;
        t_secondary;
        t_clear_neg;
        t_product;
        t_test_cmpar;
        t_flags_wrap;
        t_ignored;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule